// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the bookkeeping of interrupt entry and exit for a small 4-bit controller core. When the interrupt arbiter acknowledges a source, the sequencer spends one dedicated cycle on the entry. In that cycle it pulses a clear for the global interrupt enable and for the request flag of that source. It pushes the address that would have executed next onto the address stack, and it saves the system-register bits (bank, register pointer, status) onto a separate interrupt stack. It also hands the core the vector address of the source as the new program counter.

A return-from-interrupt strobe pops both stacks in one cycle. It returns the saved address as the next program counter and the saved register bits for the core to restore. Ordinary subroutine calls and returns, including return-and-skip, use the same address stack but never touch the interrupt stack. A stack overflow or underflow sets a sticky error flag and leaves the stored entries intact.

Top module: `irq_seq`

## Requirements
- R1: After synchronous reset, sp_o equals the address stack depth (8 by default, meaning empty), and pc_load_o, regs_load_o, ien_clr_o, req_clr_o and err_o are all 0.
- R2: One clock after ack_i, ien_clr_o is 1 and req_clr_o has only bit ack_src_i set. pc_load_o is 1 with pc_val_o equal to the vector of that source, which by default is 0x010*(source+1). These outputs last exactly one cycle.
- R3: An acknowledge decrements sp_o by one and stores next_pc_i at the new stack position. A later pop returns exactly that value.
- R4: An acknowledge saves the fields {bank_i[1:0], rptr_i[4:0], stat_i[4:0]} on the interrupt stack, and regs_load_o stays 0 in the entry cycle.
- R5: One clock after reti_i, pc_load_o is 1 with the top address entry, regs_load_o is 1 with the top interrupt-stack fields on bank_o, rptr_o and stat_o, and sp_o has risen by one.
- R6: ret_i (plain return or return-and-skip) pops the address stack like reti_i but leaves regs_load_o at 0 and the interrupt stack unchanged.
- R7: call_i pushes next_pc_i on the address stack and decrements sp_o. It raises no pc_load_o, no flag clear, and does not touch the interrupt stack.
- R8: Nested entries and returns come back in last-in first-out order on both stacks.
- R9: A push on a full address stack (sp_o = 0) sets err_o, leaves sp_o and all stored entries unchanged, and err_o stays 1 until reset. An acknowledge still clears the flags and loads the vector.
- R10: A pop on an empty address stack sets err_o, keeps sp_o, and raises no pc_load_o.
- R11: When several strobes are active in the same cycle, only one acts. The order of precedence is ack_i first, then reti_i, then ret_i, then call_i.
- R12: The interrupt stack has its own depth (4 by default). Pushing it when full or popping it when empty sets err_o without affecting the address stack operation of the same cycle, and regs_load_o stays 0 on such a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_src_i | input | 2 | Index of the acknowledged source |
| next_pc_i | input | 12 | Address that would execute next |
| bank_i | input | 2 | Current low bank bits |
| rptr_i | input | 5 | Current low register-pointer bits |
| stat_i | input | 5 | Current status bits |
| call_i | input | 1 | Subroutine call: push next_pc_i |
| ret_i | input | 1 | Plain return or return-and-skip: pop address |
| reti_i | input | 1 | Interrupt return: pop address and registers |
| pc_load_o | output | 1 | Load pc_val_o into the program counter |
| pc_val_o | output | 12 | Vector or popped address |
| regs_load_o | output | 1 | Restore bank_o, rptr_o, stat_o |
| bank_o | output | 2 | Restored bank bits |
| rptr_o | output | 5 | Restored register-pointer bits |
| stat_o | output | 5 | Restored status bits |
| sp_o | output | 4 | Address stack pointer (8 = empty) |
| ien_clr_o | output | 1 | Clear global interrupt enable |
| req_clr_o | output | 4 | One-hot clear of request flags |
| err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
The bench nests interrupts inside a call. A design that shared one pointer for both stacks, or restored registers on a plain return, would then hand back the wrong bank and status fields on the outer interrupt return. The address stack is filled to the limit and pushed once more, then drained. A design that decremented past zero, or wrote the rejected push, would return a corrupted first entry. The bench also drives simultaneous strobes, where a wrong precedence shows up as a pop in place of a push. It overflows only the interrupt stack, which checks that the address push still goes ahead while the register restore is withheld on the unmatched return.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int BANK_W = 2;
  localparam int RPTR_W = 5;
  localparam int STAT_W = 5;
  localparam int REGS_W = BANK_W + RPTR_W + STAT_W;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [RPTR_W-1:0] rptr;
    logic [STAT_W-1:0] stat;
  } sysregs_t;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_ENTER,
    ACT_RETI,
    ACT_RET,
    ACT_CALL
  } act_e;
endpackage

// File: rtl/irq_lifo.sv
module irq_lifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic          full,
  output logic          empty,
  output logic [PW-1:0] ptr,
  output logic [W-1:0]  dout,
  output logic          rd_vld
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          do_push;
  logic          do_pop;

  assign full    = (ptr == '0);
  assign empty   = (ptr == PW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wr_addr = AW'(ptr - PW'(1));
  assign rd_addr = AW'(ptr);

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= PW'(DEPTH);
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= do_pop;
      if (do_push)     ptr <= ptr - PW'(1);
      else if (do_pop) ptr <= ptr + PW'(1);
    end
  end

  always_comb begin
    if (!rst) AST_PTR_BOUND: assert (ptr <= PW'(DEPTH)); // R9
  end

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    push && full |=> $stable(ptr)); // R9

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (rst)
    pop && empty && !push |=> !rd_vld && $stable(ptr)); // R10
endmodule

// File: rtl/irq_vec_lut.sv
module irq_vec_lut #(
  parameter int NSRC = 4,
  parameter int AW   = 12,
  parameter logic [NSRC*AW-1:0] VEC_TABLE = '0,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic [SW-1:0] src,
  output logic [AW-1:0] vec
);
  logic [AW-1:0] tbl [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_vec
    assign tbl[g] = VEC_TABLE[g*AW +: AW];
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (32'(src) == i) vec = tbl[i];
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int AW     = 12,
  parameter int DEPTH  = 8,
  parameter int IDEPTH = 4,
  parameter int NSRC   = 4,
  parameter logic [NSRC*AW-1:0] VEC_TABLE = {12'h040, 12'h030, 12'h020, 12'h010},
  localparam int SW    = $clog2(NSRC),
  localparam int SPW   = $clog2(DEPTH + 1),
  localparam int ISPW  = $clog2(IDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_i,
  input  logic [SW-1:0]     ack_src_i,
  input  logic [AW-1:0]     next_pc_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [RPTR_W-1:0] rptr_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              reti_i,
  output logic              pc_load_o,
  output logic [AW-1:0]     pc_val_o,
  output logic              regs_load_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [RPTR_W-1:0] rptr_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [SPW-1:0]    sp_o,
  output logic              ien_clr_o,
  output logic [NSRC-1:0]   req_clr_o,
  output logic              err_o
);
  act_e            act;
  logic            a_push, a_pop, a_full, a_empty, a_vld;
  logic            i_push, i_pop, i_full, i_empty, i_vld;
  logic [AW-1:0]   a_dout;
  logic [REGS_W-1:0] i_dout;
  logic [ISPW-1:0] isp;
  sysregs_t        cur_regs;
  sysregs_t        rest_regs;
  logic [AW-1:0]   vec;
  logic [AW-1:0]   vec_q;
  logic            enter_q;
  logic            err_q;

  // one action per cycle, acknowledge first
  always_comb begin
    if (ack_i)       act = ACT_ENTER;
    else if (reti_i) act = ACT_RETI;
    else if (ret_i)  act = ACT_RET;
    else if (call_i) act = ACT_CALL;
    else             act = ACT_IDLE;
  end

  assign a_push = (act == ACT_ENTER) || (act == ACT_CALL);
  assign a_pop  = (act == ACT_RETI)  || (act == ACT_RET);
  assign i_push = (act == ACT_ENTER);
  assign i_pop  = (act == ACT_RETI);

  assign cur_regs = '{bank: bank_i, rptr: rptr_i, stat: stat_i};

  irq_lifo #(.W(AW), .DEPTH(DEPTH)) u_addr_stk (
    .clk(clk), .rst(rst), .push(a_push), .pop(a_pop), .din(next_pc_i),
    .full(a_full), .empty(a_empty), .ptr(sp_o), .dout(a_dout), .rd_vld(a_vld)
  );

  irq_lifo #(.W(REGS_W), .DEPTH(IDEPTH)) u_regs_stk (
    .clk(clk), .rst(rst), .push(i_push), .pop(i_pop), .din(cur_regs),
    .full(i_full), .empty(i_empty), .ptr(isp), .dout(i_dout), .rd_vld(i_vld)
  );

  irq_vec_lut #(.NSRC(NSRC), .AW(AW), .VEC_TABLE(VEC_TABLE)) u_vec (
    .src(ack_src_i), .vec(vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enter_q   <= 1'b0;
      vec_q     <= '0;
      ien_clr_o <= 1'b0;
      req_clr_o <= '0;
      err_q     <= 1'b0;
    end else begin
      enter_q   <= (act == ACT_ENTER);
      ien_clr_o <= (act == ACT_ENTER);
      req_clr_o <= (act == ACT_ENTER) ? (NSRC'(1) << ack_src_i) : '0;
      if (act == ACT_ENTER) vec_q <= vec;
      err_q <= err_q | (a_push && a_full) | (a_pop && a_empty)
                     | (i_push && i_full) | (i_pop && i_empty);
    end
  end

  assign rest_regs   = sysregs_t'(i_dout);
  assign pc_load_o   = enter_q || a_vld;
  assign pc_val_o    = enter_q ? vec_q : a_dout;
  assign regs_load_o = i_vld;
  assign bank_o      = rest_regs.bank;
  assign rptr_o      = rest_regs.rptr;
  assign stat_o      = rest_regs.stat;
  assign err_o       = err_q;

  AST_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> ien_clr_o && $countones(req_clr_o) == 1 && pc_load_o && !regs_load_o); // R2

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
    (ack_i || (call_i && !ret_i && !reti_i)) && sp_o != '0 |=> sp_o == $past(sp_o) - SPW'(1)); // R3

  AST_RET_NO_RESTORE: assert property (@(posedge clk) disable iff (rst)
    ret_i && !ack_i && !reti_i |=> !regs_load_o); // R6

  AST_CALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    call_i && !ack_i && !ret_i && !reti_i |=> !pc_load_o && !ien_clr_o && req_clr_o == '0); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R9

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ret_i || reti_i) && !ack_i && sp_o == SPW'(DEPTH) |=> !pc_load_o && err_o); // R10
endmodule

// File: tb/tb_irq_seq.sv
module tb_irq_seq;
  localparam int DEPTH  = 8;
  localparam int IDEPTH = 4;

  typedef struct {
    string      tag;
    logic       pcl;
    logic [11:0] pcv;
    logic       rl;
    logic [11:0] regs;
    logic [3:0] sp;
    logic       err;
    logic       ien;
    logic [3:0] req;
  } exp_t;

  logic clk = 0, rst = 1;
  logic ack_i = 0, call_i = 0, ret_i = 0, reti_i = 0;
  logic [1:0] ack_src_i = 0;
  logic [11:0] next_pc_i = 0;
  logic [1:0] bank_i = 0;
  logic [4:0] rptr_i = 0, stat_i = 0;
  logic pc_load_o, regs_load_o, ien_clr_o, err_o;
  logic [11:0] pc_val_o;
  logic [1:0] bank_o;
  logic [4:0] rptr_o, stat_o;
  logic [3:0] sp_o, req_clr_o;

  irq_seq dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  exp_t q[$];

  logic [11:0] m_astk [DEPTH];
  logic [11:0] m_istk [IDEPTH];
  int m_sp, m_isp;
  logic m_err;

  // monitor: compare one expected item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pc_load_o !== e.pcl || (e.pcl && pc_val_o !== e.pcv) ||
          regs_load_o !== e.rl || (e.rl && {bank_o, rptr_o, stat_o} !== e.regs) ||
          sp_o !== e.sp || err_o !== e.err || ien_clr_o !== e.ien || req_clr_o !== e.req) begin
        errors++;
        $display("FAIL %s: got pcl=%0b pcv=%h rl=%0b regs=%h sp=%0d err=%0b ien=%0b req=%b exp pcl=%0b pcv=%h rl=%0b regs=%h sp=%0d err=%0b ien=%0b req=%b",
          e.tag, pc_load_o, pc_val_o, regs_load_o, {bank_o, rptr_o, stat_o}, sp_o, err_o,
          ien_clr_o, req_clr_o, e.pcl, e.pcv, e.rl, e.regs, e.sp, e.err, e.ien, e.req);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got cycles=%0d exp below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1; ack_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_sp = DEPTH; m_isp = IDEPTH; m_err = 0;
    q.push_back('{tag, 1'b0, 12'h0, 1'b0, 12'h0, 4'(DEPTH), 1'b0, 1'b0, 4'b0});
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic cyc(string tag, logic ack, logic [1:0] src, logic [11:0] pc,
                     logic [11:0] regs, logic call, logic ret, logic reti);
    exp_t e;
    @(negedge clk);
    ack_i = ack; ack_src_i = src; next_pc_i = pc;
    {bank_i, rptr_i, stat_i} = regs;
    call_i = call; ret_i = ret; reti_i = reti;
    e = '{tag, 1'b0, 12'h0, 1'b0, 12'h0, 4'h0, 1'b0, 1'b0, 4'b0};
    if (ack) begin
      e.ien = 1; e.req = 4'(1 << src); e.pcl = 1; e.pcv = 12'(16 * (src + 1));
      if (m_sp == 0) m_err = 1; else begin m_sp--; m_astk[m_sp] = pc; end
      if (m_isp == 0) m_err = 1; else begin m_isp--; m_istk[m_isp] = regs; end
    end else if (reti || ret) begin
      if (m_sp == DEPTH) m_err = 1;
      else begin e.pcl = 1; e.pcv = m_astk[m_sp]; m_sp++; end
      if (reti) begin
        if (m_isp == IDEPTH) m_err = 1;
        else begin e.rl = 1; e.regs = m_istk[m_isp]; m_isp++; end
      end
    end else if (call) begin
      if (m_sp == 0) m_err = 1; else begin m_sp--; m_astk[m_sp] = pc; end
    end
    e.sp = 4'(m_sp); e.err = m_err;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    do_reset("R1 reset state");
    // entry, call, nested entry, then unwinding
    cyc("R2 R3 R4 entry src2", 1, 2, 12'h123, {2'd2, 5'h15, 5'h0A}, 0, 0, 0);
    idle("R2 one-cycle pulses");
    cyc("R7 call", 0, 0, 12'h200, 0, 1, 0, 0);
    cyc("R8 nested entry src0", 1, 0, 12'h300, {2'd1, 5'h03, 5'h1F}, 0, 0, 0);
    cyc("R5 R8 inner reti", 0, 0, 0, 0, 0, 0, 1);
    cyc("R6 plain return", 0, 0, 0, 0, 0, 1, 0);
    cyc("R5 R6 R8 outer reti", 0, 0, 0, 0, 0, 0, 1);
    cyc("R2 entry src3", 1, 3, 12'h456, {2'd3, 5'h1E, 5'h11}, 0, 0, 0);
    cyc("R5 reti after src3", 0, 0, 0, 0, 0, 0, 1);
    // simultaneous strobes
    cyc("R11 ack wins all", 1, 1, 12'h777, {2'd0, 5'h0C, 5'h05}, 1, 1, 1);
    cyc("R11 reti beats call", 0, 0, 12'h888, 0, 1, 0, 1);
    cyc("R7 call", 0, 0, 12'h999, 0, 1, 0, 0);
    cyc("R11 ret beats call", 0, 0, 12'hAAA, 0, 1, 1, 0);
    idle("R1 idle");
    // address stack overflow
    do_reset("R1 reset again");
    for (int i = 0; i < DEPTH; i++) cyc("R9 fill", 0, 0, 12'(12'h100 + i), 0, 1, 0, 0);
    cyc("R9 call overflow", 0, 0, 12'hBAD, 0, 1, 0, 0);
    cyc("R9 entry overflow keeps vector", 1, 1, 12'hBEE, {2'd1, 5'h01, 5'h01}, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) cyc("R9 drain intact", 0, 0, 0, 0, 0, 1, 0);
    // interrupt stack overflow
    do_reset("R1 reset third");
    for (int i = 0; i < IDEPTH + 1; i++)
      cyc("R12 entries", 1, 2'(i), 12'(12'h500 + i), 12'(12'h0A0 + i), 0, 0, 0);
    for (int i = 0; i < IDEPTH + 1; i++) cyc("R12 R8 unwind", 0, 0, 0, 0, 0, 0, 1);
    // underflow
    do_reset("R1 reset fourth");
    cyc("R10 ret on empty", 0, 0, 0, 0, 0, 1, 0);
    cyc("R10 reti on empty", 0, 0, 0, 0, 0, 0, 1);
    cyc("R12 call then reti without regs", 0, 0, 12'h321, 0, 1, 0, 0);
    cyc("R12 reti pops address only", 0, 0, 0, 0, 0, 0, 1);
    idle("R9 err sticky");
    @(negedge clk);
    ack_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule